// File: doc/BRIEF.md
# Global TLB Invalidation Engine

This block holds a small TLB entry array and applies invalidate requests to it. Each entry carries a page number, a page mask, a 2-bit address region, a memory-map identifier, an address-space identifier, a global bit and an invalidated flag. A request comes in one of two ways. The first is an instruction word, which the block decodes itself, including a check of a 2-bit capability field. The second is a local invalidate strobe, which drops the entries of the current identity.

An accepted request starts a walk over the entries, from index 0 up to the last, one entry per cycle. Each visited entry that the selection rule picks gets its invalidated flag set. During the walk `busy` is high, and a one-cycle `done` pulse follows the walk. Entries are loaded through a fill port, and any entry's invalidated flag can be read through a probe port. Illegal instruction forms raise a one-cycle reserved-instruction pulse.

Top module: `tlbinv_engine`

## Requirements
- R1: An instruction word counts as an invalidate instruction only when bits 31:26 equal 0x1F and bits 5:0 equal 0x3D. Any other word has no effect: no walk starts and `ri_exc` stays low.
- R2: If a recognised instruction arrives while the engine is idle and `cap_field` is 0 or 1, `ri_exc` is high for exactly the next cycle and no walk starts.
- R3: With `cap_field` of 2 or 3, bits 7:6 of the word pick the action. A value of 0 is a no-op: no walk and no `ri_exc`. A value of 2 starts a TLB walk whose type is bits 9:8. A value of 1 or 3 raises `ri_exc` in the next cycle.
- R4: Type 0 invalidates every entry whose index is strictly greater than `wired_idx`, whatever the entry's other fields hold.
- R5: Type 1 invalidates every entry whose address matches, whatever its MMID and global bit.
- R6: Type 2 invalidates every non-global entry whose MMID equals `cur_mmid`.
- R7: Type 3 invalidates every entry whose address matches and that is either global or has an MMID equal to `cur_mmid`.
- R8: An address match requires two things. The entry's page number and the request page number (taken from `req_va[61:13]`) must agree on every bit where the entry's mask is 0. The entry's region must also equal `req_va[63:62]`.
- R9: A local invalidate marks every non-global entry whose identity equals the current identity. With `mmid_mode` at 1 that identity is the MMID (`cur_mmid`). With `mmid_mode` at 0 it is the ASID (`cur_asid`).
- R10: After a start is accepted at a clock edge, `busy` is high for exactly ENTRIES cycles, one per entry. `done` is then high for exactly one cycle, with `busy` low.
- R11: While `busy` is high, instructions and local strobes are ignored. In an idle cycle where a recognised instruction and a local strobe arrive together, the instruction is acted on and the strobe is ignored.
- R12: Reset sets every entry's invalidated flag and clears `busy`, `done` and `ri_exc`. A fill loads the entry and clears its flag. If a fill and a walk invalidation hit the same entry in the same cycle, the fill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word present |
| instr_word | input | 32 | Instruction word to decode |
| cap_field | input | 2 | Capability level; 2 or more allows the instruction |
| req_va | input | VA_W | Request address: region and page number |
| cur_mmid | input | MMID_W | Current memory-map identifier |
| cur_asid | input | ASID_W | Current address-space identifier |
| mmid_mode | input | 1 | Local identity is MMID (1) or ASID (0) |
| wired_idx | input | IDX_W | Wired boundary for type 0 |
| local_inv | input | 1 | Local invalidate strobe |
| fill_en | input | 1 | Load an entry |
| fill_idx | input | IDX_W | Entry to load |
| fill_vpn2 | input | VPN_W | Page number to load |
| fill_mask | input | VPN_W | Page mask to load (1 = ignored bit) |
| fill_region | input | 2 | Region to load |
| fill_mmid | input | MMID_W | MMID to load |
| fill_asid | input | ASID_W | ASID to load |
| fill_global | input | 1 | Global bit to load |
| probe_idx | input | IDX_W | Entry whose flag is read |
| probe_inv | output | 1 | Invalidated flag of the probed entry |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse after the walk |
| ri_exc | output | 1 | Reserved-instruction pulse |

## Verification
The assertions check the walk's timing on every cycle: the busy length, the single `done` pulse and its link to the end of `busy`. They also check, on every cycle, the capability and no-op decode outcomes and that a filled entry reads back as valid. Which entries each type, mask, region and identity combination selects can only be shown by the bench scenarios. The same goes for ignoring requests during a walk, instruction priority over the local strobe, and a fill colliding with a walk invalidation. The bench runs a behavioural model alongside the design and checks the count and position of invalidated entries against hand-computed values.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

   typedef enum logic [2:0] {
      KIND_ALL   = 3'd0,
      KIND_VA    = 3'd1,
      KIND_ID    = 3'd2,
      KIND_VA_ID = 3'd3,
      KIND_LOCAL = 3'd4
   } inv_kind_e;

   localparam logic [5:0] MAJOR_OP  = 6'h1F;
   localparam logic [5:0] FUNC_INV  = 6'h3D;
   localparam logic [1:0] SEL_CACHE = 2'd0;
   localparam logic [1:0] SEL_TLB   = 2'd2;

   function automatic logic cap_allows(input logic [1:0] cap);
      return cap >= 2'd2;
   endfunction

endpackage

// File: rtl/tlbinv_decode.sv
module tlbinv_decode
   import tlbinv_pkg::*;
(
   input  logic        valid,
   input  logic        idle,
   input  logic [31:0] word,
   input  logic [1:0]  cap,
   output logic        claim,
   output logic        start_tlb,
   output inv_kind_e   kind,
   output logic        raise_ri
);

   logic unused_bits;
   assign unused_bits = ^word[25:10];

   always_comb begin
      claim     = valid && idle && (word[31:26] == MAJOR_OP) && (word[5:0] == FUNC_INV);
      start_tlb = 1'b0;
      raise_ri  = 1'b0;
      kind      = inv_kind_e'({1'b0, word[9:8]});
      if (claim) begin
         if (!cap_allows(cap)) begin
            raise_ri = 1'b1;
         end else if (word[7:6] == SEL_TLB) begin
            start_tlb = 1'b1;
         end else if (word[7:6] != SEL_CACHE) begin
            raise_ri = 1'b1;
         end
      end
   end

endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
   import tlbinv_pkg::*;
#(
   parameter int VPN_W        = 49,
   parameter int ID_W         = 16,
   parameter int IDX_W        = 4,
   parameter int REGION_CHECK = 1
) (
   input  inv_kind_e          kind,
   input  logic [IDX_W-1:0]   idx,
   input  logic [IDX_W-1:0]   wired,
   input  logic [VPN_W-1:0]   e_vpn,
   input  logic [VPN_W-1:0]   e_mask,
   input  logic [1:0]         e_region,
   input  logic [ID_W-1:0]    e_mmid,
   input  logic [ID_W-1:0]    e_asid,
   input  logic               e_glob,
   input  logic [VPN_W-1:0]   r_vpn,
   input  logic [1:0]         r_region,
   input  logic [ID_W-1:0]    r_mmid,
   input  logic [ID_W-1:0]    r_ident,
   input  logic               r_mode,
   output logic               hit
);

   logic region_eq;
   logic va_hit;
   logic mmid_eq;
   logic local_hit;

   if (REGION_CHECK != 0) begin : g_region
      assign region_eq = (e_region == r_region);
   end else begin : g_no_region
      logic unused_region;
      assign unused_region = ^{e_region, r_region};
      assign region_eq = 1'b1;
   end

   assign va_hit    = (((e_vpn ^ r_vpn) & ~e_mask) == '0) && region_eq;
   assign mmid_eq   = (e_mmid == r_mmid);
   assign local_hit = !e_glob && ((r_mode ? e_mmid : e_asid) == r_ident);

   always_comb begin
      unique case (kind)
         KIND_ALL:   hit = (idx > wired);
         KIND_VA:    hit = va_hit;
         KIND_ID:    hit = mmid_eq && !e_glob;
         KIND_VA_ID: hit = va_hit && (e_glob || mmid_eq);
         KIND_LOCAL: hit = local_hit;
         default:    hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/tlbinv_store.sv
module tlbinv_store #(
   parameter int N      = 16,
   parameter int IDX_W  = 4,
   parameter int VPN_W  = 49,
   parameter int MMID_W = 16,
   parameter int ASID_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fill_en,
   input  logic [IDX_W-1:0]   fill_idx,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [VPN_W-1:0]   fill_mask,
   input  logic [1:0]         fill_region,
   input  logic [MMID_W-1:0]  fill_mmid,
   input  logic [ASID_W-1:0]  fill_asid,
   input  logic               fill_glob,
   input  logic               kill_en,
   input  logic [IDX_W-1:0]   kill_idx,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [VPN_W-1:0]   rd_vpn,
   output logic [VPN_W-1:0]   rd_mask,
   output logic [1:0]         rd_region,
   output logic [MMID_W-1:0]  rd_mmid,
   output logic [ASID_W-1:0]  rd_asid,
   output logic               rd_glob,
   input  logic [IDX_W-1:0]   probe_idx,
   output logic               probe_inv
);

   logic [VPN_W-1:0]  vpn_q    [N];
   logic [VPN_W-1:0]  mask_q   [N];
   logic [1:0]        region_q [N];
   logic [MMID_W-1:0] mmid_q   [N];
   logic [ASID_W-1:0] asid_q   [N];
   logic              glob_q   [N];
   logic              inv_q    [N];

   for (genvar i = 0; i < N; i++) begin : g_entry
      logic wr_here;
      logic kill_here;
      assign wr_here   = fill_en && (fill_idx == IDX_W'(i));
      assign kill_here = kill_en && (kill_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vpn_q[i]    <= '0;
            mask_q[i]   <= '0;
            region_q[i] <= '0;
            mmid_q[i]   <= '0;
            asid_q[i]   <= '0;
            glob_q[i]   <= 1'b0;
            inv_q[i]    <= 1'b1;
         end else if (wr_here) begin
            vpn_q[i]    <= fill_vpn;
            mask_q[i]   <= fill_mask;
            region_q[i] <= fill_region;
            mmid_q[i]   <= fill_mmid;
            asid_q[i]   <= fill_asid;
            glob_q[i]   <= fill_glob;
            inv_q[i]    <= 1'b0;
         end else if (kill_here) begin
            inv_q[i]    <= 1'b1;
         end
      end
   end

   assign rd_vpn    = vpn_q[rd_idx];
   assign rd_mask   = mask_q[rd_idx];
   assign rd_region = region_q[rd_idx];
   assign rd_mmid   = mmid_q[rd_idx];
   assign rd_asid   = asid_q[rd_idx];
   assign rd_glob   = glob_q[rd_idx];
   assign probe_inv = inv_q[probe_idx];

endmodule

// File: rtl/tlbinv_walk.sv
module tlbinv_walk
   import tlbinv_pkg::*;
#(
   parameter int N     = 16,
   parameter int IDX_W = 4,
   parameter int VPN_W = 49,
   parameter int ID_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  inv_kind_e          s_kind,
   input  logic [VPN_W-1:0]   s_vpn,
   input  logic [1:0]         s_region,
   input  logic [ID_W-1:0]    s_mmid,
   input  logic [ID_W-1:0]    s_ident,
   input  logic               s_mode,
   input  logic [IDX_W-1:0]   s_wired,
   output logic               busy,
   output logic               done,
   output logic [IDX_W-1:0]   idx,
   output inv_kind_e          q_kind,
   output logic [VPN_W-1:0]   q_vpn,
   output logic [1:0]         q_region,
   output logic [ID_W-1:0]    q_mmid,
   output logic [ID_W-1:0]    q_ident,
   output logic               q_mode,
   output logic [IDX_W-1:0]   q_wired
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

   typedef enum logic {ST_IDLE, ST_WALK} walk_state_e;
   walk_state_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         done     <= 1'b0;
         idx      <= '0;
         q_kind   <= KIND_ALL;
         q_vpn    <= '0;
         q_region <= '0;
         q_mmid   <= '0;
         q_ident  <= '0;
         q_mode   <= 1'b0;
         q_wired  <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_WALK;
                  idx      <= '0;
                  q_kind   <= s_kind;
                  q_vpn    <= s_vpn;
                  q_region <= s_region;
                  q_mmid   <= s_mmid;
                  q_ident  <= s_ident;
                  q_mode   <= s_mode;
                  q_wired  <= s_wired;
               end
            end
            ST_WALK: begin
               if (idx == LAST) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end else begin
                  idx <= idx + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state == ST_WALK);

endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
   import tlbinv_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int VA_W       = 64,
   parameter int PAGE_SHIFT = 12,
   parameter int IS64       = 1,
   parameter int MMID_W     = 16,
   parameter int ASID_W     = 8,
   localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int VPN_LO    = PAGE_SHIFT + 1,
   localparam int VPN_HI    = (IS64 != 0) ? VA_W - 3 : VA_W - 1,
   localparam int VPN_W     = VPN_HI - VPN_LO + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [31:0]        instr_word,
   input  logic [1:0]         cap_field,
   input  logic [VA_W-1:0]    req_va,
   input  logic [MMID_W-1:0]  cur_mmid,
   input  logic [ASID_W-1:0]  cur_asid,
   input  logic               mmid_mode,
   input  logic [IDX_W-1:0]   wired_idx,
   input  logic               local_inv,
   input  logic               fill_en,
   input  logic [IDX_W-1:0]   fill_idx,
   input  logic [VPN_W-1:0]   fill_vpn2,
   input  logic [VPN_W-1:0]   fill_mask,
   input  logic [1:0]         fill_region,
   input  logic [MMID_W-1:0]  fill_mmid,
   input  logic [ASID_W-1:0]  fill_asid,
   input  logic               fill_global,
   input  logic [IDX_W-1:0]   probe_idx,
   output logic               probe_inv,
   output logic               busy,
   output logic               done,
   output logic               ri_exc
);

   localparam int ID_W = MMID_W;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("tlbinv_engine: ENTRIES must be at least 2");
   end
   if (MMID_W < ASID_W) begin : g_bad_id
      $error("tlbinv_engine: MMID_W must be at least ASID_W");
   end
   if (VPN_W < 1 || PAGE_SHIFT < 1) begin : g_bad_va
      $error("tlbinv_engine: address geometry leaves no page number");
   end

   logic [VPN_W-1:0] req_vpn;
   logic [1:0]       req_region;
   assign req_vpn = req_va[VPN_HI:VPN_LO];

   if (IS64 != 0) begin : g_wide
      assign req_region = req_va[VA_W-1:VA_W-2];
   end else begin : g_narrow
      assign req_region = 2'b00;
   end

   logic unused_va;
   assign unused_va = ^req_va[VPN_LO-1:0];

   logic      dec_claim;
   logic      dec_start;
   inv_kind_e dec_kind;
   logic      dec_ri;
   logic      walk_busy;

   tlbinv_decode u_decode (
      .valid     (instr_valid),
      .idle      (!walk_busy),
      .word      (instr_word),
      .cap       (cap_field),
      .claim     (dec_claim),
      .start_tlb (dec_start),
      .kind      (dec_kind),
      .raise_ri  (dec_ri)
   );

   logic      local_start;
   logic      start_any;
   inv_kind_e start_kind;
   logic [ID_W-1:0] start_ident;

   assign local_start = local_inv && !walk_busy && !dec_claim;
   assign start_any   = dec_start || local_start;
   assign start_kind  = dec_start ? dec_kind : KIND_LOCAL;
   assign start_ident = mmid_mode ? cur_mmid : ID_W'(cur_asid);

   logic [IDX_W-1:0] w_idx;
   inv_kind_e        q_kind;
   logic [VPN_W-1:0] q_vpn;
   logic [1:0]       q_region;
   logic [ID_W-1:0]  q_mmid;
   logic [ID_W-1:0]  q_ident;
   logic             q_mode;
   logic [IDX_W-1:0] q_wired;

   tlbinv_walk #(
      .N     (ENTRIES),
      .IDX_W (IDX_W),
      .VPN_W (VPN_W),
      .ID_W  (ID_W)
   ) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start_any),
      .s_kind   (start_kind),
      .s_vpn    (req_vpn),
      .s_region (req_region),
      .s_mmid   (cur_mmid),
      .s_ident  (start_ident),
      .s_mode   (mmid_mode),
      .s_wired  (wired_idx),
      .busy     (walk_busy),
      .done     (done),
      .idx      (w_idx),
      .q_kind   (q_kind),
      .q_vpn    (q_vpn),
      .q_region (q_region),
      .q_mmid   (q_mmid),
      .q_ident  (q_ident),
      .q_mode   (q_mode),
      .q_wired  (q_wired)
   );

   logic [VPN_W-1:0]  e_vpn;
   logic [VPN_W-1:0]  e_mask;
   logic [1:0]        e_region;
   logic [MMID_W-1:0] e_mmid;
   logic [ASID_W-1:0] e_asid;
   logic              e_glob;
   logic              sel_hit;

   tlbinv_store #(
      .N      (ENTRIES),
      .IDX_W  (IDX_W),
      .VPN_W  (VPN_W),
      .MMID_W (MMID_W),
      .ASID_W (ASID_W)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .fill_en     (fill_en),
      .fill_idx    (fill_idx),
      .fill_vpn    (fill_vpn2),
      .fill_mask   (fill_mask),
      .fill_region (fill_region),
      .fill_mmid   (fill_mmid),
      .fill_asid   (fill_asid),
      .fill_glob   (fill_global),
      .kill_en     (walk_busy && sel_hit),
      .kill_idx    (w_idx),
      .rd_idx      (w_idx),
      .rd_vpn      (e_vpn),
      .rd_mask     (e_mask),
      .rd_region   (e_region),
      .rd_mmid     (e_mmid),
      .rd_asid     (e_asid),
      .rd_glob     (e_glob),
      .probe_idx   (probe_idx),
      .probe_inv   (probe_inv)
   );

   tlbinv_match #(
      .VPN_W        (VPN_W),
      .ID_W         (ID_W),
      .IDX_W        (IDX_W),
      .REGION_CHECK (IS64)
   ) u_match (
      .kind     (q_kind),
      .idx      (w_idx),
      .wired    (q_wired),
      .e_vpn    (e_vpn),
      .e_mask   (e_mask),
      .e_region (e_region),
      .e_mmid   (e_mmid),
      .e_asid   (ID_W'(e_asid)),
      .e_glob   (e_glob),
      .r_vpn    (q_vpn),
      .r_region (q_region),
      .r_mmid   (q_mmid),
      .r_ident  (q_ident),
      .r_mode   (q_mode),
      .hit      (sel_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ri_exc <= 1'b0;
      else        ri_exc <= dec_ri;
   end

   assign busy = walk_busy;

endmodule

// File: rtl/tlbinv_engine_chk.sv
module tlbinv_engine_chk #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             instr_valid,
   input logic [31:0]      instr_word,
   input logic [1:0]       cap_field,
   input logic             fill_en,
   input logic [IDX_W-1:0] fill_idx,
   input logic [IDX_W-1:0] probe_idx,
   input logic             probe_inv,
   input logic             busy,
   input logic             done,
   input logic             ri_exc
);

   logic [IDX_W+1:0] busy_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 1'b1;
      else           busy_cnt <= '0;
   end

   logic is_inv_instr;
   assign is_inv_instr = instr_valid && (instr_word[31:26] == 6'h1F) && (instr_word[5:0] == 6'h3D);

   assert_walk_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (busy_cnt == (IDX_W+2)'(ENTRIES)));

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_cap_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (is_inv_instr && !busy && cap_field < 2'd2) |=> (ri_exc && !busy));

   assert_cache_nop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (is_inv_instr && !busy && cap_field >= 2'd2 && instr_word[7:6] == 2'd0) |=> (!ri_exc && !busy));

   assert_ri_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ri_exc |-> !busy);

   assert_fill_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> ((probe_idx != $past(fill_idx)) || !probe_inv));

endmodule

bind tlbinv_engine tlbinv_engine_chk #(
   .ENTRIES (ENTRIES),
   .IDX_W   (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .instr_word  (instr_word),
   .cap_field   (cap_field),
   .fill_en     (fill_en),
   .fill_idx    (fill_idx),
   .probe_idx   (probe_idx),
   .probe_inv   (probe_inv),
   .busy        (busy),
   .done        (done),
   .ri_exc      (ri_exc)
);

// File: tb/tlbinv_engine_test.sv
module tlbinv_engine_test;

   localparam int N = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr_word = '0;
   logic [1:0]  cap_field = 2'd3;
   logic [63:0] req_va = '0;
   logic [15:0] cur_mmid = '0;
   logic [7:0]  cur_asid = '0;
   logic        mmid_mode = 1'b0;
   logic [3:0]  wired_idx = '0;
   logic        local_inv = 1'b0;
   logic        fill_en = 1'b0;
   logic [3:0]  fill_idx = '0;
   logic [48:0] fill_vpn2 = '0;
   logic [48:0] fill_mask = '0;
   logic [1:0]  fill_region = '0;
   logic [15:0] fill_mmid = '0;
   logic [7:0]  fill_asid = '0;
   logic        fill_global = 1'b0;
   logic [3:0]  probe_idx = '0;
   logic        probe_inv;
   logic        busy;
   logic        done;
   logic        ri_exc;

   always #2.5 clk = ~clk;

   tlbinv_engine uut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
      .cap_field(cap_field), .req_va(req_va), .cur_mmid(cur_mmid), .cur_asid(cur_asid),
      .mmid_mode(mmid_mode), .wired_idx(wired_idx), .local_inv(local_inv),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn2(fill_vpn2), .fill_mask(fill_mask),
      .fill_region(fill_region), .fill_mmid(fill_mmid), .fill_asid(fill_asid),
      .fill_global(fill_global), .probe_idx(probe_idx), .probe_inv(probe_inv),
      .busy(busy), .done(done), .ri_exc(ri_exc)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   // Behavioural reference model
   logic [48:0] e_vpn [N];
   logic [48:0] e_mask [N];
   logic [1:0]  e_reg [N];
   int          e_mmid [N];
   int          e_asid [N];
   bit          e_g [N];
   bit          e_inv [N];
   bit m_busy, m_done, m_ri;
   int m_widx;
   int q_kind, q_mmid, q_ident, q_wired;
   logic [48:0] q_vpn;
   logic [1:0]  q_reg;
   bit q_mode;

   function automatic bit m_hit(input int i);
      bit va;
      va = (((e_vpn[i] ^ q_vpn) & ~e_mask[i]) == 49'd0) && (e_reg[i] == q_reg);
      case (q_kind)
         0: return i > q_wired;
         1: return va;
         2: return !e_g[i] && e_mmid[i] == q_mmid;
         3: return va && (e_g[i] || e_mmid[i] == q_mmid);
         4: return !e_g[i] && ((q_mode ? e_mmid[i] : e_asid[i]) == q_ident);
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy = 0; m_done = 0; m_ri = 0; m_widx = 0;
         for (int i = 0; i < N; i++) begin
            e_vpn[i] = '0; e_mask[i] = '0; e_reg[i] = '0;
            e_mmid[i] = 0; e_asid[i] = 0; e_g[i] = 0; e_inv[i] = 1;
         end
      end else begin
         m_done = 0;
         m_ri = 0;
         if (m_busy) begin
            if (m_hit(m_widx)) e_inv[m_widx] = 1;
            if (m_widx == N - 1) begin
               m_busy = 0;
               m_done = 1;
            end else begin
               m_widx++;
            end
         end else if (instr_valid && instr_word[31:26] == 6'h1F && instr_word[5:0] == 6'h3D) begin
            if (cap_field < 2'd2) m_ri = 1;
            else if (instr_word[7:6] == 2'd2) begin
               m_busy = 1; m_widx = 0;
               q_kind = int'(instr_word[9:8]);
               q_vpn = req_va[61:13]; q_reg = req_va[63:62];
               q_mmid = int'(cur_mmid); q_wired = int'(wired_idx);
            end else if (instr_word[7:6] != 2'd0) m_ri = 1;
         end else if (local_inv) begin
            m_busy = 1; m_widx = 0; q_kind = 4;
            q_mode = mmid_mode;
            q_ident = mmid_mode ? int'(cur_mmid) : int'(cur_asid);
         end
         if (fill_en) begin
            e_vpn[fill_idx] = fill_vpn2; e_mask[fill_idx] = fill_mask;
            e_reg[fill_idx] = fill_region; e_mmid[fill_idx] = int'(fill_mmid);
            e_asid[fill_idx] = int'(fill_asid); e_g[fill_idx] = fill_global;
            e_inv[fill_idx] = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(busy == m_busy, "R10 busy", int'(busy), int'(m_busy));
         chk(done == m_done, "R10 done", int'(done), int'(m_done));
         chk(ri_exc == m_ri, "R2 ri_exc", int'(ri_exc), int'(m_ri));
         chk(probe_inv == e_inv[probe_idx], "R12 probe flag", int'(probe_inv), int'(e_inv[probe_idx]));
      end
   end

   function automatic logic [31:0] mk(input logic [1:0] sel, input logic [1:0] typ, input logic [5:0] fn);
      return {6'h1F, 16'd0, typ, sel, fn};
   endfunction

   task automatic fill_one(input int i);
      @(posedge clk); #1;
      fill_en = 1; fill_idx = 4'(i);
      fill_vpn2 = 49'(i % 4);
      fill_mask = (i == 5) ? 49'd1 : 49'd0;
      fill_region = (i == 7) ? 2'd1 : 2'd0;
      fill_mmid = 16'(100 + i % 3);
      fill_asid = 8'(i % 2);
      fill_global = (i % 5 == 0);
      @(posedge clk); #1;
      fill_en = 0;
   endtask

   task automatic refill();
      for (int i = 0; i < N; i++) fill_one(i);
   endtask

   task automatic issue(input logic [31:0] w, input logic [1:0] cap, input logic [1:0] rg,
                        input logic [48:0] vpn, input logic [15:0] mm, input logic [3:0] wi);
      @(posedge clk); #1;
      instr_valid = 1; instr_word = w; cap_field = cap;
      req_va = {rg, vpn, 13'd0}; cur_mmid = mm; wired_idx = wi;
      @(posedge clk); #1;
      instr_valid = 0;
   endtask

   task automatic local_req(input logic mode, input logic [15:0] mm, input logic [7:0] asid);
      @(posedge clk); #1;
      local_inv = 1; mmid_mode = mode; cur_mmid = mm; cur_asid = asid;
      @(posedge clk); #1;
      local_inv = 0;
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   task automatic count_inv(output int c);
      c = 0;
      for (int i = 0; i < N; i++) begin
         @(posedge clk); #1;
         probe_idx = 4'(i);
         @(negedge clk);
         c += int'(probe_inv);
      end
   endtask

   task automatic probe(input int i, output bit v);
      @(posedge clk); #1;
      probe_idx = 4'(i);
      @(negedge clk);
      v = probe_inv;
   endtask

   task automatic finish_run();
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10 act=%0d exp=%0d", 0, 1);
      finish_run();
   end

   initial begin
      int c;
      bit v;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(!busy && !done && !ri_exc, "R12 reset outputs", int'({busy, done, ri_exc}), 0);
      count_inv(c);
      chk(c == 16, "R12 reset all invalid", c, 16);

      refill();
      count_inv(c);
      chk(c == 0, "R12 fill clears flags", c, 0);

      // R4: type 0, wired 9
      issue(mk(2'd2, 2'd0, 6'h3D), 2'd3, 2'd0, 49'd0, 16'd0, 4'd9);
      wait_done();
      count_inv(c);
      chk(c == 6, "R4 type0 count", c, 6);
      probe(9, v);  chk(v == 0, "R4 wired entry kept", int'(v), 0);
      probe(10, v); chk(v == 1, "R4 entry above wired", int'(v), 1);

      // R5 / R8: type 1, page 0, mask alias on entry 5
      refill();
      issue(mk(2'd2, 2'd1, 6'h3D), 2'd2, 2'd0, 49'd0, 16'd555, 4'd0);
      wait_done();
      count_inv(c);
      chk(c == 5, "R5 type1 count", c, 5);
      probe(5, v); chk(v == 1, "R8 masked page match", int'(v), 1);

      // R8: region mismatch keeps entry 7
      refill();
      issue(mk(2'd2, 2'd1, 6'h3D), 2'd2, 2'd0, 49'd3, 16'd0, 4'd0);
      wait_done();
      count_inv(c);
      chk(c == 3, "R8 region count", c, 3);
      probe(7, v); chk(v == 0, "R8 region mismatch kept", int'(v), 0);

      // R6: type 2
      refill();
      issue(mk(2'd2, 2'd2, 6'h3D), 2'd3, 2'd0, 49'd0, 16'd101, 4'd0);
      wait_done();
      count_inv(c);
      chk(c == 4, "R6 type2 count", c, 4);
      probe(10, v); chk(v == 0, "R6 global kept", int'(v), 0);

      // R7: type 3
      refill();
      issue(mk(2'd2, 2'd3, 6'h3D), 2'd3, 2'd0, 49'd2, 16'd100, 4'd0);
      wait_done();
      count_inv(c);
      chk(c == 2, "R7 type3 count", c, 2);
      probe(10, v); chk(v == 1, "R7 global va hit", int'(v), 1);

      // R9: local, MMID mode then ASID mode
      refill();
      local_req(1'b1, 16'd102, 8'd0);
      wait_done();
      count_inv(c);
      chk(c == 4, "R9 local mmid count", c, 4);
      refill();
      local_req(1'b0, 16'd0, 8'd1);
      wait_done();
      count_inv(c);
      chk(c == 6, "R9 local asid count", c, 6);

      // R2 / R3 / R1 decode outcomes
      refill();
      issue(mk(2'd2, 2'd0, 6'h3D), 2'd1, 2'd0, 49'd0, 16'd0, 4'd0);
      @(negedge clk);
      chk(ri_exc == 1 && busy == 0, "R2 low capability", int'({ri_exc, busy}), 2);
      issue(mk(2'd1, 2'd0, 6'h3D), 2'd2, 2'd0, 49'd0, 16'd0, 4'd0);
      @(negedge clk);
      chk(ri_exc == 1, "R3 select 1 reserved", int'(ri_exc), 1);
      issue(mk(2'd3, 2'd0, 6'h3D), 2'd3, 2'd0, 49'd0, 16'd0, 4'd0);
      @(negedge clk);
      chk(ri_exc == 1, "R3 select 3 reserved", int'(ri_exc), 1);
      issue(mk(2'd0, 2'd0, 6'h3D), 2'd3, 2'd0, 49'd0, 16'd0, 4'd0);
      @(negedge clk);
      chk(ri_exc == 0 && busy == 0, "R3 cache select no-op", int'({ri_exc, busy}), 0);
      issue(mk(2'd2, 2'd0, 6'h3C), 2'd3, 2'd0, 49'd0, 16'd0, 4'd0);
      @(negedge clk);
      chk(ri_exc == 0 && busy == 0, "R1 foreign word", int'({ri_exc, busy}), 0);
      count_inv(c);
      chk(c == 0, "R1 no entries touched", c, 0);

      // R11: requests during a walk ignored
      issue(mk(2'd2, 2'd0, 6'h3D), 2'd3, 2'd0, 49'd0, 16'd0, 4'd9);
      issue(mk(2'd2, 2'd1, 6'h3D), 2'd3, 2'd0, 49'd0, 16'd0, 4'd0);
      local_req(1'b0, 16'd0, 8'd0);
      wait_done();
      count_inv(c);
      chk(c == 6, "R11 busy ignores requests", c, 6);

      // R11: instruction wins over local strobe
      refill();
      @(posedge clk); #1;
      instr_valid = 1; instr_word = mk(2'd0, 2'd0, 6'h3D); cap_field = 2'd3;
      local_inv = 1; mmid_mode = 0; cur_asid = 8'd1;
      @(posedge clk); #1;
      instr_valid = 0; local_inv = 0;
      @(negedge clk);
      chk(busy == 0, "R11 instruction priority", int'(busy), 0);

      // R12: fill collides with walk on entry 12
      issue(mk(2'd2, 2'd1, 6'h3D), 2'd3, 2'd0, 49'd0, 16'd0, 4'd0);
      repeat (11) @(posedge clk);
      fill_one(12);
      wait_done();
      probe(12, v);
      chk(v == 0, "R12 fill wins collision", int'(v), 0);
      count_inv(c);
      chk(c == 4, "R12 collision count", c, 4);

      repeat (4) @(posedge clk);
      finish_run();
   end

endmodule